// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Decoder

This block is the device-side front end that turns a block-erase transaction on a serial flash bus into a single erase request. The serial pins are assumed to be already synchronised into the system clock domain. The block samples the data input on each rising edge of the serial clock while chip select is low. It collects an eight-bit command byte followed by a 24-bit address, and it checks the command against the three supported erase sizes.

When chip select returns high, the block decides whether the transaction was a complete, permitted erase. For a valid erase it issues a one-cycle request. The request carries a block-aligned base address and a size code, and it raises a busy flag. The erase engine then runs self-timed and reports back with a done pulse. That pulse drops busy and tells the status logic to clear its write-enable latch.

Incomplete frames, unknown commands, a cleared write-enable latch, or a new command while an erase is running all leave the request line quiet. The serial output driver stays disabled throughout.

Top module: `erase_dec_top`

## Requirements
- R1: Command byte 0x20 gives size code 0 (4 KB), 0x52 gives size code 1 (32 KB) and 0xD8 gives size code 2 (64 KB); size code 3 is never issued with a request.
- R2: A request is issued only if `welIn` is high on the clock edge where chip select is first seen high; otherwise the transaction is dropped.
- R3: While `csN` is low, each rising `sck` shifts in one bit from `si`. The first 8 bits form the command, most significant bit first, and the next 24 bits form address bits 23 down to 0, most significant bit first.
- R4: Bits shifted in after the 32nd have no effect on the issued address or size.
- R5: `eraseReq` never rises while `csN` is low. It is a single-cycle pulse, high in the cycle after the clock edge that first sees `csN` high.
- R6: If fewer than 24 address bits arrived before `csN` rose, no request is issued.
- R7: `eraseBase` equals the received address with bits 11..0 cleared for size 0, bits 14..0 cleared for size 1, and bits 15..0 cleared for size 2.
- R8: `busy` rises together with `eraseReq` and stays high until `eraseDone`. Erase transactions that end while `busy` is high issue no request and leave `eraseBase` and `eraseSize` unchanged.
- R9: An `eraseDone` pulse while `busy` is high drops `busy` and produces a one-cycle `welClr` pulse in the next cycle. An `eraseDone` while idle produces no `welClr`.
- R10: A command byte other than the three erase codes issues no request.
- R11: `soOe` is low at all times.
- R12: After reset, `eraseReq`, `busy` and `welClr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, synchronised |
| csN | input | 1 | Chip select, active low, synchronised |
| si | input | 1 | Serial data in |
| welIn | input | 1 | Current value of the write-enable latch |
| eraseDone | input | 1 | Pulse from the erase engine when the erase finishes |
| soOe | output | 1 | Serial output enable, held low |
| eraseReq | output | 1 | One-cycle erase request |
| eraseBase | output | 24 | Block-aligned base address |
| eraseSize | output | 2 | Size code: 0 = 4 KB, 1 = 32 KB, 2 = 64 KB |
| busy | output | 1 | Erase in progress |
| welClr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
A stuck or miscounted bit counter shows up at the ports as a wrong base address, or as a missing or spurious request. This is visible one cycle after chip select rises on the very next frame. A shift register that keeps absorbing bits past the frame moves the address and changes the decoded size, so trailing-bit frames expose it at once. A busy state that is lost or never set shows either as a second request while an erase is running, or as a missing `welClr` one cycle after `eraseDone`.

// File: rtl/erase_dec_pkg.sv
package erase_dec_pkg;
  localparam int OP_W = 8;
  localparam int ADDR_W = 24;
  localparam int FRAME_BITS = OP_W + ADDR_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  localparam logic [OP_W-1:0] OP_ERASE_4K = 8'h20;
  localparam logic [OP_W-1:0] OP_ERASE_32K = 8'h52;
  localparam logic [OP_W-1:0] OP_ERASE_64K = 8'hD8;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_32K = 2'd1,
    SZ_64K = 2'd2,
    SZ_NONE = 2'd3
  } blkSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic shift;
    logic capture;
  } dpCtl_t;

  function automatic blkSize_e decodeOp(input logic [OP_W-1:0] op);
    case (op)
      OP_ERASE_4K: return SZ_4K;
      OP_ERASE_32K: return SZ_32K;
      OP_ERASE_64K: return SZ_64K;
      default: return SZ_NONE;
    endcase
  endfunction

  function automatic int unsigned dropBits(input blkSize_e sz);
    case (sz)
      SZ_4K: return 12;
      SZ_32K: return 15;
      SZ_64K: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] alignMask(input blkSize_e sz);
    logic [ADDR_W-1:0] m;
    m = '1;
    m = m << dropBits(sz);
    return m;
  endfunction
endpackage

// File: rtl/erase_dec_dp.sv
module erase_dec_dp
  import erase_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              si,
  output logic              opValid,
  output logic [ADDR_W-1:0] eraseBase,
  output logic [1:0]        eraseSize
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_BITS);

  logic [FRAME_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]      bitCnt;
  logic                  frameFull;
  blkSize_e              opSize;

  assign frameFull = (bitCnt == FULL_CNT);
  assign opSize = decodeOp(shiftReg[FRAME_BITS-1 -: OP_W]);
  assign opValid = frameFull && (opSize != SZ_NONE);

  // frame shifter; stops at a full frame so trailing bits are dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt <= '0;
    end else if (ctl.clear) begin
      shiftReg <= '0;
      bitCnt <= '0;
    end else if (ctl.shift && !frameFull) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], si};
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseBase <= '0;
      eraseSize <= SZ_4K;
    end else if (ctl.capture) begin
      eraseBase <= shiftReg[ADDR_W-1:0] & alignMask(opSize);
      eraseSize <= opSize;
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT); // R4
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (frameFull && !ctl.clear) |=> $stable(shiftReg)); // R4
endmodule

// File: rtl/erase_dec_ctl.sv
module erase_dec_ctl
  import erase_dec_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sck,
  input  logic   csN,
  input  logic   welIn,
  input  logic   opValid,
  input  logic   eraseDone,
  output dpCtl_t ctl,
  output logic   eraseReq,
  output logic   busy,
  output logic   welClr
);
  typedef enum logic {ST_IDLE, ST_ERASING} state_e;

  state_e state;
  logic   sckPrev;
  logic   csPrev;
  logic   csRise;
  logic   accept;

  assign csRise = csN && !csPrev;
  assign accept = csRise && opValid && welIn && (state == ST_IDLE);
  assign busy = (state == ST_ERASING);

  always_comb begin
    ctl.clear = csN;
    ctl.shift = sck && !sckPrev && !csN;
    ctl.capture = accept;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev <= 1'b1;
      state <= ST_IDLE;
      eraseReq <= 1'b0;
      welClr <= 1'b0;
    end else begin
      sckPrev <= sck;
      csPrev <= csN;
      eraseReq <= accept;
      welClr <= busy && eraseDone;
      case (state)
        ST_IDLE: if (accept) state <= ST_ERASING;
        ST_ERASING: if (eraseDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> $past(welIn)); // R2
  AST_REQ_AFTER_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> $past(csN)); // R5
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |=> !eraseReq); // R5
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> !$past(busy)); // R8
  AST_BUSY_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> busy); // R8
  AST_WELCLR_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    welClr |-> ($past(eraseDone) && $past(busy) && !busy)); // R9
endmodule

// File: rtl/erase_dec_top.sv
module erase_dec_top
  import erase_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  input  logic              welIn,
  input  logic              eraseDone,
  output logic              soOe,
  output logic              eraseReq,
  output logic [ADDR_W-1:0] eraseBase,
  output logic [1:0]        eraseSize,
  output logic              busy,
  output logic              welClr
);
  dpCtl_t ctl;
  logic   opValid;

  assign soOe = 1'b0;

  erase_dec_ctl u_ctl (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .welIn(welIn),
    .opValid(opValid), .eraseDone(eraseDone), .ctl(ctl),
    .eraseReq(eraseReq), .busy(busy), .welClr(welClr)
  );

  erase_dec_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .si(si),
    .opValid(opValid), .eraseBase(eraseBase), .eraseSize(eraseSize)
  );

  AST_SIZE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> (eraseSize != SZ_NONE)); // R1
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    eraseReq |-> ((eraseBase & ~alignMask(blkSize_e'(eraseSize))) == '0)); // R7
  AST_BASE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eraseReq) |-> $stable(eraseBase)); // R8
endmodule

// File: tb/erase_dec_top_bench.sv
module erase_dec_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [5:0]  nAddr;
    logic        wel;
    logic        expReq;
    logic [1:0]  expSize;
    logic [23:0] expBase;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    {8'h20, 24'h123456, 6'd24, 1'b1, 1'b1, 2'd0, 24'h123000},
    {8'h52, 24'hABCDEF, 6'd24, 1'b1, 1'b1, 2'd1, 24'hAB8000},
    {8'hD8, 24'hFEDCBA, 6'd24, 1'b1, 1'b1, 2'd2, 24'hFE0000},
    {8'h20, 24'hFFFFFF, 6'd24, 1'b1, 1'b1, 2'd0, 24'hFFF000},
    {8'h52, 24'h007FFF, 6'd24, 1'b1, 1'b1, 2'd1, 24'h000000},
    {8'h20, 24'h123456, 6'd24, 1'b0, 1'b0, 2'd0, 24'h000000},
    {8'h20, 24'h123456, 6'd23, 1'b1, 1'b0, 2'd0, 24'h000000},
    {8'h9F, 24'h123456, 6'd24, 1'b1, 1'b0, 2'd0, 24'h000000},
    {8'hD8, 24'h000000, 6'd0,  1'b1, 1'b0, 2'd0, 24'h000000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic csN = 1'b1;
  logic si = 1'b0;
  logic welIn = 1'b0;
  logic eraseDone = 1'b0;
  logic soOe;
  logic eraseReq;
  logic [23:0] eraseBase;
  logic [1:0] eraseSize;
  logic busy;
  logic welClr;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  erase_dec_top u_erase_dec_top (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .si(si), .welIn(welIn),
    .eraseDone(eraseDone), .soOe(soOe), .eraseReq(eraseReq),
    .eraseBase(eraseBase), .eraseSize(eraseSize), .busy(busy), .welClr(welClr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sendBit(input logic b);
    @(negedge clk) sck = 1'b0; si = b;
    @(negedge clk) sck = 1'b1;
  endtask

  // R3: command then address, both MSB first
  task automatic runFrame(input logic [7:0] op, input logic [23:0] addr,
                          input int nAddr, input int nExtra, input logic wel);
    welIn = wel;
    @(negedge clk) csN = 1'b0; sck = 1'b0;
    for (int i = 7; i >= 0; i--) sendBit(op[i]);
    for (int i = 0; i < nAddr; i++) sendBit(addr[23 - i]);
    for (int i = 0; i < nExtra; i++) sendBit(1'b1);
    @(negedge clk) sck = 1'b0;
    chk("R5 no req while cs low", 32'(eraseReq), 0);
    chk("R11 so disabled", 32'(soOe), 0);
    @(negedge clk) csN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishErase();
    @(negedge clk) eraseDone = 1'b1;
    @(negedge clk) eraseDone = 1'b0;
    chk("R9 busy drops", 32'(busy), 0);
    chk("R9 welClr pulse", 32'(welClr), 1);
    @(negedge clk);
    chk("R9 welClr one cycle", 32'(welClr), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 req reset", 32'(eraseReq), 0);
    chk("R12 busy reset", 32'(busy), 0);
    chk("R12 welClr reset", 32'(welClr), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      runFrame(VECS[v].op, VECS[v].addr, int'(VECS[v].nAddr), 0, VECS[v].wel);
      chk("R1/R2/R6/R10 request", 32'(eraseReq), 32'(VECS[v].expReq));
      if (VECS[v].expReq) begin
        chk("R1 size", 32'(eraseSize), 32'(VECS[v].expSize));
        chk("R7 base", 32'(eraseBase), 32'(VECS[v].expBase));
        chk("R8 busy set", 32'(busy), 1);
        @(negedge clk);
        chk("R5 req single cycle", 32'(eraseReq), 0);
        finishErase();
      end else begin
        chk("R8 busy idle", 32'(busy), 0);
      end
    end

    // R4: trailing ones after the address must not move it
    runFrame(8'h52, 24'h13579B, 24, 8, 1'b1);
    chk("R4 req", 32'(eraseReq), 1);
    chk("R4 base", 32'(eraseBase), 32'h130000);
    chk("R4 size", 32'(eraseSize), 1);
    finishErase();

    // R8: command during busy is ignored
    runFrame(8'h20, 24'h456789, 24, 0, 1'b1);
    chk("R8 first req", 32'(eraseReq), 1);
    runFrame(8'hD8, 24'hABCDEF, 24, 0, 1'b1);
    chk("R8 no req while busy", 32'(eraseReq), 0);
    chk("R8 busy held", 32'(busy), 1);
    chk("R8 base unchanged", 32'(eraseBase), 32'h456000);
    chk("R8 size unchanged", 32'(eraseSize), 0);
    finishErase();

    // R9: done while idle gives no clear
    @(negedge clk) eraseDone = 1'b1;
    @(negedge clk) eraseDone = 1'b0;
    chk("R9 no welClr when idle", 32'(welClr), 0);
    chk("R11 so disabled idle", 32'(soOe), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule